// File: doc/BRIEF.md
# Background Memory CRC Error Monitor

This block watches a protected configuration memory while the device runs. Through a simple read port it walks every word of the memory from the lowest to the highest address, again and again. Each word goes into a 32-bit CRC, processed from its most significant bit down. A single reference CRC, loaded in advance, covers the whole memory. There is no per-region checksum.

When a scan finishes, the running CRC is combined by XOR with the stored reference value, and the result is written to the signature register. When the memory is intact the signature is zero. Any non-zero signature raises the error flag. The flag stays high until a later pass gives a zero signature, a new reference is loaded, or reset is applied.

Scanning takes place only while the enable is high, which marks normal operation after configuration has finished. The reference can be replaced only while the enable is low. A load clears the signature and the error flag, and it starts a fresh scan.

Top module: `bg_crc_monitor`

## Requirements
- R1: While `scan_en` is high, `mem_rd` is high every cycle and `mem_addr` steps upward by one per cycle. Read data is taken one cycle after its address. While `scan_en` is low, `mem_rd` is low.
- R2: The running CRC uses polynomial 0x04C11DB7 and starts each pass at 0xFFFFFFFF. It processes each word MSB first, with no bit reflection and no output inversion.
- R3: At the end of a pass, `signature` equals the pass CRC XOR the stored reference value. It is therefore zero for an intact memory whose reference matches.
- R4: `signature` changes only on the clock edge that consumes the word at address DEPTH-1, or on a load. It holds its value at all other times.
- R5: `crc_error` is high exactly when `signature` is non-zero. Once high, it stays high until a pass ends with a zero signature, a load occurs, or reset is applied.
- R6: After address DEPTH-1, the scan wraps to address 0 and the next pass starts again from the initial CRC value.
- R7: A `ref_load` pulse while `scan_en` is high is ignored. The reference, the scan address and the signature are left unchanged.
- R8: A `ref_load` while `scan_en` is low stores `ref_value`. It clears `signature` and `crc_error`, moves the scan back to address 0, and discards any read still in flight.
- R9: Taking `scan_en` low in the middle of a pass pauses the scan without losing progress. Raising it again finishes the same pass and gives the same signature as an uninterrupted pass.
- R10: Reset gives `signature` = 0, `crc_error` = 0, a zero reference and `mem_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_en | input | 1 | High in normal operation; allows the background scan to run |
| mem_rd | output | 1 | Read strobe to the protected memory |
| mem_addr | output | AW = clog2(DEPTH) | Word address being read |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| ref_load | input | 1 | Load strobe for the reference CRC (accepted only while `scan_en` is low) |
| ref_value | input | 32 | Precomputed reference CRC to store |
| signature | output | 32 | Residue of the last completed pass (CRC XOR reference) |
| crc_error | output | 1 | High while the signature is non-zero |

## Verification
The bench builds the block with DEPTH = 4 and DATA_W = 8, so one pass lasts only a few cycles and the whole memory holds 32 bits. This makes it practical to flip every single memory bit in turn and to flip every bit of the reference in turn. Each result is compared with a CRC that the bench computes bit by bit. The small depth also puts the wrap point, a pause in the middle of a pass, a load attempted during a scan, and the release of a latched error within a handful of cycles, so each one is checked at the exact edge where the signature should or should not change.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

  // One read beat travelling from the address stage to the CRC stage
  typedef struct packed {
    logic valid;
    logic last;
  } beat_t;
endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import crc_mon_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  output logic          rd,
  output logic [AW-1:0] addr,
  output beat_t         beat
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q, addr_nx;
  beat_t         beat_q, beat_nx;

  always_comb begin
    addr_nx       = addr_q;
    beat_nx.valid = 1'b0;
    beat_nx.last  = 1'b0;
    if (restart) begin
      addr_nx = '0;
    end else if (run) begin
      addr_nx       = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
      beat_nx.valid = 1'b1;
      beat_nx.last  = (addr_q == LAST_ADDR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      beat_q <= '0;
    end else begin
      addr_q <= addr_nx;
      beat_q <= beat_nx;
    end
  end

  assign rd   = run;
  assign addr = addr_q;
  assign beat = beat_q;
endmodule

// File: rtl/crc_run_unit.sv
module crc_run_unit
  import crc_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  beat_t            beat,
  input  logic [DATA_W-1:0] data,
  output logic             pass_end,
  output logic [CRC_W-1:0] pass_crc
);
  logic [CRC_W-1:0] crc_q, crc_nx, crc_step;
  logic             take;

  function automatic logic [CRC_W-1:0] fold_word(input logic [CRC_W-1:0] c,
                                                 input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  assign take     = beat.valid && !restart;
  assign crc_step = fold_word(crc_q, data);

  always_comb begin
    crc_nx = crc_q;
    if (restart)                crc_nx = CRC_INIT;
    else if (take && beat.last) crc_nx = CRC_INIT;
    else if (take)              crc_nx = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_nx;
  end

  assign pass_end = take && beat.last;
  assign pass_crc = crc_step;
endmodule

// File: rtl/sig_hold.sv
module sig_hold
  import crc_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRC_W-1:0] load_val,
  input  logic             pass_end,
  input  logic [CRC_W-1:0] pass_crc,
  output logic [CRC_W-1:0] ref_val,
  output logic [CRC_W-1:0] sig,
  output logic             err
);
  logic [CRC_W-1:0] ref_q, ref_nx, sig_q, sig_nx, residue;
  logic             err_q, err_nx;

  assign residue = pass_crc ^ ref_q;

  always_comb begin
    ref_nx = ref_q;
    sig_nx = sig_q;
    err_nx = err_q;
    if (load) begin
      ref_nx = load_val;
      sig_nx = '0;
      err_nx = 1'b0;
    end else if (pass_end) begin
      sig_nx = residue;
      err_nx = |residue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      sig_q <= '0;
      err_q <= 1'b0;
    end else begin
      ref_q <= ref_nx;
      sig_q <= sig_nx;
      err_q <= err_nx;
    end
  end

  assign ref_val = ref_q;
  assign sig     = sig_q;
  assign err     = err_q;
endmodule

// File: rtl/bg_crc_monitor.sv
module bg_crc_monitor
  import crc_mon_pkg::*;
#(
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ref_load,
  input  logic [31:0]       ref_value,
  output logic [31:0]       signature,
  output logic              crc_error
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             run, load_acc, pass_end;
  beat_t            beat;
  logic [CRC_W-1:0] pass_crc, ref_val;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign run      = scan_en && rst_n_s;
  assign load_acc = ref_load && !scan_en;

  scan_addr_gen #(.DEPTH(DEPTH)) addr_i (
    .clk(clk), .rst_n(rst_n_s), .run(run), .restart(load_acc),
    .rd(mem_rd), .addr(mem_addr), .beat(beat)
  );

  crc_run_unit #(.DATA_W(DATA_W)) crc_i (
    .clk(clk), .rst_n(rst_n_s), .restart(load_acc), .beat(beat),
    .data(mem_rdata), .pass_end(pass_end), .pass_crc(pass_crc)
  );

  sig_hold sig_i (
    .clk(clk), .rst_n(rst_n_s), .load(load_acc), .load_val(ref_value),
    .pass_end(pass_end), .pass_crc(pass_crc), .ref_val(ref_val),
    .sig(signature), .err(crc_error)
  );
endmodule

// File: rtl/bg_crc_monitor_chk.sv
module bg_crc_monitor_chk #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_en,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          ref_load,
  input logic [31:0]   signature,
  input logic          crc_error,
  input logic          pass_end,
  input logic          load_acc,
  input logic [31:0]   ref_val
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  p_no_read_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !mem_rd);

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !load_acc && mem_addr != LAST_ADDR) |=> mem_addr == $past(mem_addr) + 1'b1);

  p_sig_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_end && !load_acc) |=> $stable(signature));

  p_err_matches_sig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error == (signature != 32'h0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr == LAST_ADDR) |=> mem_addr == '0);

  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_load && scan_en) |=> $stable(ref_val));

  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> (signature == 32'h0 && !crc_error && mem_addr == '0));
endmodule

bind bg_crc_monitor bg_crc_monitor_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .scan_en(scan_en), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .ref_load(ref_load), .signature(signature),
  .crc_error(crc_error), .pass_end(pass_end), .load_acc(load_acc),
  .ref_val(ref_val)
);

// File: tb/bg_crc_monitor_tb_top.sv
module bg_crc_monitor_tb_top;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned NBITS  = DEPTH * DATA_W;

  logic              clk;
  logic              rst_n, scan_en, ref_load, mem_rd, crc_error;
  logic [AW-1:0]     mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic [31:0]       ref_value, signature;
  logic [DATA_W-1:0] mem [DEPTH];

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  bg_crc_monitor #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ref_load(ref_load),
    .ref_value(ref_value), .signature(signature), .crc_error(crc_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Synchronous read memory, one cycle latency
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int w = 0; w < DEPTH; w++)
      for (int b = DATA_W - 1; b >= 0; b--) begin
        fb = c[31] ^ mem[w][b];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ref(input logic [31:0] v);
    ref_load = 1'b1; ref_value = v;
    edges(1);
    ref_load = 1'b0;
    chk("R8 sig cleared", signature, 32'h0);
    chk("R8 err cleared", {31'h0, crc_error}, 32'h0);
    chk("R8 addr restart", {{(32-AW){1'b0}}, mem_addr}, 32'h0);
  endtask

  // Full pass from address 0; checks hold before the last edge and the result after it
  task automatic scan_pass(input logic [31:0] prev, input logic [31:0] exp, input string tag);
    scan_en = 1'b1;
    edges(DEPTH);
    chk({tag, " R4 held mid pass"}, signature, prev);
    chk("R1 reading", {31'h0, mem_rd}, 32'h1);
    chk("R6 wrapped to 0", {{(32-AW){1'b0}}, mem_addr}, 32'h0);
    edges(1);
    chk({tag, " R3 signature"}, signature, exp);
    chk({tag, " R5 flag"}, {31'h0, crc_error}, {31'h0, exp != 32'h0});
    scan_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] good, e;
    rst_n = 1'b0; scan_en = 1'b0; ref_load = 1'b0; ref_value = '0;
    for (int w = 0; w < DEPTH; w++) mem[w] = DATA_W'(8'h3C + w * 8'h51);
    edges(3);
    chk("R10 sig reset", signature, 32'h0);
    chk("R10 err reset", {31'h0, crc_error}, 32'h0);
    chk("R10 addr reset", {{(32-AW){1'b0}}, mem_addr}, 32'h0);
    chk("R1 no read idle", {31'h0, mem_rd}, 32'h0);
    rst_n = 1'b1;
    edges(3);

    // R10: zero reference after reset, so signature is the raw CRC (R2)
    scan_pass(32'h0, ref_crc(), "R2 R10 raw crc");

    good = ref_crc();
    load_ref(good);
    scan_pass(32'h0, 32'h0, "intact");

    // R2/R3: every single memory bit flipped
    for (int b = 0; b < NBITS; b++) begin
      mem[b / DATA_W][b % DATA_W] ^= 1'b1;
      e = ref_crc() ^ good;
      load_ref(good);
      scan_pass(32'h0, e, "R2 bitflip");
      chk("R5 bitflip nonzero", {31'h0, e != 32'h0}, 32'h1);
      mem[b / DATA_W][b % DATA_W] ^= 1'b1;
    end

    // R3: every reference bit flipped on an intact memory
    for (int i = 0; i < 32; i++) begin
      load_ref(good ^ (32'h1 << i));
      scan_pass(32'h0, 32'h1 << i, "R3 refflip");
    end

    // R5: flag persists until a clean pass
    load_ref(good);
    mem[DEPTH-1] ^= 8'h10;
    e = ref_crc() ^ good;
    scan_pass(32'h0, e, "R5 corrupt");
    edges(2);
    mem[DEPTH-1] ^= 8'h10;
    scan_en = 1'b1;
    edges(DEPTH - 1);
    chk("R5 flag held", {31'h0, crc_error}, 32'h1);
    edges(1);
    chk("R5 flag released sig", signature, 32'h0);
    chk("R5 flag released", {31'h0, crc_error}, 32'h0);
    scan_en = 1'b0;

    // R7: load during scan ignored
    load_ref(good);
    scan_en = 1'b1;
    edges(2);
    ref_load = 1'b1; ref_value = 32'hDEADBEEF;
    edges(1);
    ref_load = 1'b0;
    chk("R7 addr not restarted", {{(32-AW){1'b0}}, mem_addr}, 32'd3);
    chk("R7 sig unchanged", signature, 32'h0);
    edges(2);
    chk("R7 old reference kept", signature, 32'h0);
    chk("R7 no error", {31'h0, crc_error}, 32'h0);
    scan_en = 1'b0;

    // R9: pause mid pass
    mem[2] ^= 8'h01;
    e = ref_crc() ^ good;
    load_ref(good);
    scan_en = 1'b1;
    edges(2);
    scan_en = 1'b0;
    edges(5);
    chk("R9 paused sig", signature, 32'h0);
    chk("R9 R1 paused no read", {31'h0, mem_rd}, 32'h0);
    chk("R9 paused addr", {{(32-AW){1'b0}}, mem_addr}, 32'd2);
    scan_en = 1'b1;
    edges(DEPTH - 2);
    chk("R9 R4 held before end", signature, 32'h0);
    edges(1);
    chk("R9 resumed result", signature, e);
    chk("R9 flag", {31'h0, crc_error}, 32'h1);
    scan_en = 1'b0;

    // R10: reset clears a latched error
    rst_n = 1'b0;
    edges(1);
    chk("R10 sig after reset", signature, 32'h0);
    chk("R10 err after reset", {31'h0, crc_error}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule